// File: doc/BRIEF.md
# Quasi-Bidirectional Port with Immediate Mask Update

This block is a general-purpose I/O port for a small controller core. A single output latch sets the state of every pin. A latch bit of 0 drives its pin hard low. A latch bit of 1 only enables a weak pull-up, so an outside device can still pull that pin low. No direction register exists: software turns a pin into an input by writing a 1 into its latch bit.

The core sends one operation per cycle, qualified by `op_valid`, and selects it with a 2-bit code. A load copies the accumulator byte into the latch. Mask-AND and mask-OR combine an immediate byte with the current latch contents, and the result stays on the pins. A sample captures the present pin levels into a read register for the accumulator and leaves the latch untouched. The pin level is the wired-AND of the latch bit and the external drive. It is not stored anywhere between samples.

The operation code is decoded as an enumerated value under `unique case`. The code names are LOAD (00), MASK_AND (01), MASK_OR (10) and SAMPLE (11). The block holds no sequencing state beyond the latch and the read register. Each operation takes effect on the single clock edge on which it is presented.

Top module: `qbp_port`

## Requirements
- R1: While `rst_n` is low, and after it is released, the latch is all ones, `rd_data` is 0 and `rd_valid` is 0, so every pin starts as a pulled-up input.
- R2: `op_valid`=1 with `op_code`=00 (LOAD) makes `port_latch` equal to `op_data` after the next rising clock edge.
- R3: `op_valid`=1 with `op_code`=01 (MASK_AND) makes `port_latch` equal to the previous latch ANDed with `op_data` after the edge.
- R4: `op_valid`=1 with `op_code`=10 (MASK_OR) makes `port_latch` equal to the previous latch ORed with `op_data` after the edge.
- R5: `op_valid`=1 with `op_code`=11 (SAMPLE) leaves the latch unchanged. After the edge, `rd_data` holds the pin levels from that cycle and `rd_valid` is 1 for exactly one cycle.
- R6: While `op_valid` is 0, the latch keeps its value whatever `op_code` and `op_data` are, and `rd_valid` stays 0.
- R7: For each bit, `pad_drive_low` is the inverse of the latch bit, `pad_pullup_en` equals the latch bit, and `pin_level` is the latch bit ANDed with the inverse of `ext_pull_low`.
- R8: A pin whose latch bit is 0 reads 0 whatever the external drive.
- R9: Pin levels are not held: `rd_data` changes only on a SAMPLE, and a later change of `ext_pull_low` shows up only at the next SAMPLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Qualifies the operation in this cycle |
| op_code | input | 2 | 00 LOAD, 01 MASK_AND, 10 MASK_OR, 11 SAMPLE |
| op_data | input | WIDTH | Accumulator byte or immediate mask |
| ext_pull_low | input | WIDTH | 1 where an outside device pulls the pin low |
| port_latch | output | WIDTH | Current output latch contents |
| pad_drive_low | output | WIDTH | Strong low-side drive enable per pin |
| pad_pullup_en | output | WIDTH | Weak pull-up enable per pin |
| pin_level | output | WIDTH | Resolved level on each pin |
| rd_data | output | WIDTH | Pin levels captured by the last SAMPLE |
| rd_valid | output | 1 | One-cycle pulse after a SAMPLE |

## Verification
The bench builds the port at its default WIDTH of 8. At that width it can reach bytes with mixed bit patterns, all-ones and all-zeros latch values, and external drives that conflict with a latch bit of 0 on some pins while pulling down pulled-up pins on others. Directed scenarios chain LOAD, MASK_AND and MASK_OR so that each result depends on the previous latch value. They also hold the operation inputs at changing junk values with `op_valid` low. They change the external drive between and after SAMPLE operations to show that pin levels are never stored.

// File: rtl/qbp_pkg.sv
package qbp_pkg;
    typedef enum logic [1:0] {
        OP_LOAD     = 2'b00,
        OP_MASK_AND = 2'b01,
        OP_MASK_OR  = 2'b10,
        OP_SAMPLE   = 2'b11
    } op_e;
endpackage

// File: rtl/qbp_latch.sv
module qbp_latch
    import qbp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  op_e              op_code,
    input  logic [WIDTH-1:0] op_data,
    output logic [WIDTH-1:0] latch_q
);
    localparam logic [WIDTH-1:0] RESET_VAL = {WIDTH{1'b1}};

    logic [WIDTH-1:0] latch_d;

    always_comb begin
        latch_d = latch_q;
        if (op_valid) begin
            unique case (op_code)
                OP_LOAD:     latch_d = op_data;
                OP_MASK_AND: latch_d = latch_q & op_data;
                OP_MASK_OR:  latch_d = latch_q | op_data;
                OP_SAMPLE:   latch_d = latch_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= RESET_VAL;
        else        latch_q <= latch_d;
    end

    // R1: the cycle after reset is seen, the latch is all ones
    p_reset_ones_r1: assert property (@(posedge clk)
        !rst_n |=> latch_q == RESET_VAL);

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_LOAD) |=> latch_q == $past(op_data));

    p_and_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_MASK_AND) |=> (latch_q & ~$past(op_data)) == '0);

    p_or_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_MASK_OR) |=> (~latch_q & $past(op_data)) == '0);

    p_sample_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_SAMPLE) |=> $stable(latch_q));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(latch_q));
endmodule

// File: rtl/qbp_pad.sv
module qbp_pad #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] ext_pull_low,
    output logic [WIDTH-1:0] drive_low,
    output logic [WIDTH-1:0] pullup_en,
    output logic [WIDTH-1:0] level
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        always_comb begin
            drive_low[b] = ~latch_q[b];
            pullup_en[b] = latch_q[b];
            level[b]     = latch_q[b] & ~ext_pull_low[b];
        end
    end
endmodule

// File: rtl/qbp_sample.sv
module qbp_sample
    import qbp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  op_e              op_code,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid
);
    logic take;

    always_comb take = op_valid && (op_code == OP_SAMPLE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= take;
            if (take) rd_data <= level;
        end
    end

    p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid || $past(take));

    p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> !rd_valid);

    p_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(rd_data));
endmodule

// File: rtl/qbp_port.sv
module qbp_port
    import qbp_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [WIDTH-1:0] op_data,
    input  logic [WIDTH-1:0] ext_pull_low,
    output logic [WIDTH-1:0] port_latch,
    output logic [WIDTH-1:0] pad_drive_low,
    output logic [WIDTH-1:0] pad_pullup_en,
    output logic [WIDTH-1:0] pin_level,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_valid
);
    op_e op_sel;

    always_comb op_sel = op_e'(op_code);

    qbp_latch #(.WIDTH(WIDTH)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_sel),
        .op_data  (op_data),
        .latch_q  (port_latch)
    );

    qbp_pad #(.WIDTH(WIDTH)) u_pad (
        .latch_q      (port_latch),
        .ext_pull_low (ext_pull_low),
        .drive_low    (pad_drive_low),
        .pullup_en    (pad_pullup_en),
        .level        (pin_level)
    );

    qbp_sample #(.WIDTH(WIDTH)) u_sample (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_sel),
        .level    (pin_level),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    p_pads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_drive_low ^ pad_pullup_en) == {WIDTH{1'b1}});

    p_lowpin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_level & pad_drive_low) == '0);

    p_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == OP_SAMPLE) |=> rd_data == $past(pin_level));
endmodule

// File: tb/qbp_port_tb.sv
module qbp_port_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0;
    logic [1:0]   op_code = 2'b00;
    logic [W-1:0] op_data = '0;
    logic [W-1:0] ext_pull_low = '0;
    logic [W-1:0] port_latch, pad_drive_low, pad_pullup_en, pin_level, rd_data;
    logic         rd_valid;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    qbp_port #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_data(op_data), .ext_pull_low(ext_pull_low), .port_latch(port_latch),
        .pad_drive_low(pad_drive_low), .pad_pullup_en(pad_pullup_en),
        .pin_level(pin_level), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    logic [W-1:0] exp_latch;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // present one operation for one edge, then check at the following falling edge
    task automatic do_op(input logic [1:0] code, input logic [W-1:0] data);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = code;
        op_data  = data;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 latch in reset", port_latch, '1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 latch after reset", port_latch, '1);
        chk("R1 rd_data", rd_data, '0);
        chk("R1 rd_valid", {7'd0, rd_valid}, 8'd0);
        exp_latch = '1;
    endtask

    task automatic t_load;
        do_op(2'b00, 8'hA5);
        exp_latch = 8'hA5;
        chk("R2 load A5", port_latch, exp_latch);
        do_op(2'b00, 8'h3C);
        exp_latch = 8'h3C;
        chk("R2 load 3C", port_latch, exp_latch);
    endtask

    task automatic t_pads;
        ext_pull_low = 8'h0F;
        @(negedge clk);
        chk("R7 drive_low", pad_drive_low, ~exp_latch);
        chk("R7 pullup_en", pad_pullup_en, exp_latch);
        chk("R7 pin_level", pin_level, exp_latch & ~8'h0F);
        ext_pull_low = '0;
    endtask

    task automatic t_and;
        do_op(2'b00, 8'hA5);
        do_op(2'b01, 8'h0F);
        exp_latch = 8'h05;
        chk("R3 and 0F", port_latch, exp_latch);
        do_op(2'b01, 8'hFF);
        chk("R3 and FF keeps", port_latch, exp_latch);
    endtask

    task automatic t_or;
        do_op(2'b10, 8'hC0);
        exp_latch = 8'hC5;
        chk("R4 or C0", port_latch, exp_latch);
        do_op(2'b10, 8'h00);
        chk("R4 or 00 keeps", port_latch, exp_latch);
    endtask

    task automatic t_hold;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            op_code = i[1:0];
            op_data = 8'h5A ^ i[7:0];
            @(negedge clk);
            chk("R6 latch held", port_latch, exp_latch);
            chk("R6 no rd_valid", {7'd0, rd_valid}, 8'd0);
        end
    endtask

    task automatic t_sample;
        ext_pull_low = 8'h81;
        do_op(2'b11, 8'h00);
        chk("R5 rd_data", rd_data, 8'h44);
        chk("R5 rd_valid", {7'd0, rd_valid}, 8'd1);
        chk("R5 latch kept", port_latch, exp_latch);
        @(negedge clk);
        chk("R5 rd_valid one cycle", {7'd0, rd_valid}, 8'd0);
    endtask

    task automatic t_lowpin;
        ext_pull_low = '0;
        @(negedge clk);
        chk("R8 zero bits read low", pin_level & ~exp_latch, '0);
        do_op(2'b11, 8'hFF);
        chk("R8 sample of latch C5", rd_data, 8'hC5);
    endtask

    task automatic t_nolatch;
        ext_pull_low = 8'hFF;
        repeat (2) @(negedge clk);
        chk("R9 rd_data unchanged", rd_data, 8'hC5);
        chk("R9 live pins low", pin_level, 8'h00);
        do_op(2'b11, 8'h00);
        chk("R9 new sample", rd_data, 8'h00);
        ext_pull_low = 8'h00;
        do_op(2'b00, 8'hFF);
        do_op(2'b11, 8'h00);
        chk("R9 all inputs high", rd_data, 8'hFF);
    endtask

    initial begin
        t_reset();
        t_load();
        t_pads();
        t_and();
        t_or();
        t_hold();
        t_sample();
        t_lowpin();
        t_nolatch();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule